// File: doc/BRIEF.md
# JTAG Debug Memory Access Bridge

This block is a JTAG test access port with a 4-bit instruction register. Besides the usual identification and bypass registers, it has private data registers that let an external debugger read and write system memory through a Wishbone classic master. The debugger first loads a word address. It then moves 32-bit words through one of three data registers: read, write, or read-write. Every completed data shift leads to one bus access. After that access the held address moves on by one word, so a block of memory can be streamed without reloading the address.

The TAP logic runs on TCK. The bus master runs on the system clock. Each request crosses into the system domain, and each completion crosses back, through a toggle handshake. The word at the current address is fetched ahead of time. This happens when the address is loaded, after every increment, and on leaving Test-Logic-Reset. Capture-DR then presents that word with no bus latency. The host must spend some idle TCK cycles after Update-DR, for example in Run-Test/Idle, before the next Capture-DR. Sixteen idle cycles cover a write followed by a prefetch when TCK runs at one twelfth of the system clock.

Top module: `jtag_mem_bridge`

## Requirements
- R1: Asserting trst_n low, or holding TMS high for five TCK rising edges, puts the TAP in Test-Logic-Reset. That state selects the identification instruction and clears the word address to 0.
- R2: With opcode 4'b0001 selected, a 32-bit data shift returns 0x000018FF, least significant bit first.
- R3: Every opcode other than 4'b0001, 4'b0100, 4'b0101, 4'b0110 and 4'b0111 selects a 1-bit bypass stage. This includes 4'b0000 and 4'b1111. The stage captures 0, and in Shift-DR TDO repeats TDI one TCK later.
- R4: Capture-IR loads 4'b0001, which shifts out least significant bit first while a new opcode shifts in.
- R5: Opcode 4'b0101 selects a 30-bit address register. Shifting a new address in shifts out the address held before, least significant bit first. The new address takes effect at Update-DR.
- R6: Opcode 4'b0111 (read-write) returns the word held at the current address. At Update-DR it writes the shifted-in word to that address.
- R7: Opcode 4'b0110 (read) returns the word at the current address. The shifted-in bits are ignored and memory is left unchanged.
- R8: Opcode 4'b0100 (write) captures all zeros and writes the shifted-in word to the current address at Update-DR.
- R9: Each Update-DR of a read, write or read-write register advances the word address by exactly one.
- R10: The bus master drives wb_stb equal to wb_cyc. It holds address, write enable and write data stable until wb_ack, and releases wb_cyc on the cycle after wb_ack. A read Update-DR causes exactly one bus cycle. A write or read-write Update-DR causes exactly two: the write, then the prefetch of the next word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| trst_n | input | 1 | Asynchronous TAP reset, active low |
| tck | input | 1 | Test clock |
| tms | input | 1 | Test mode select, sampled on rising TCK |
| tdi | input | 1 | Serial data in, sampled on rising TCK |
| tdo | output | 1 | Serial data out, valid in Shift-IR and Shift-DR, 0 elsewhere |
| clk | input | 1 | System clock for the bus master |
| rst | input | 1 | Synchronous system reset, active high |
| wb_cyc | output | 1 | Bus cycle in progress |
| wb_stb | output | 1 | Bus strobe |
| wb_we | output | 1 | Bus write enable |
| wb_adr | output | 30 | Bus word address |
| wb_dat_o | output | 32 | Bus write data |
| wb_dat_i | input | 32 | Bus read data |
| wb_ack | input | 1 | Bus acknowledge |

## Verification
The hardest situation to reach is a read-write shift that must return the old word while a write and a prefetch are both still crossing clock domains. The bench drives complete TAP sequences with TCK at one twelfth of the system clock and idles in Run-Test/Idle after each update. It then streams words through the read-write register and reads them back through the read register. It compares every result against a bench memory model, and it counts bus cycles per update. It also sweeps every unassigned opcode through the bypass path, and it walks the address across the whole bench memory.

// File: rtl/jtag_mem_bridge.sv
`timescale 1ns/1ps
module jtag_mem_bridge #(
  parameter int AW = 30,
  parameter int DW = 32,
  parameter int IRW = 4,
  parameter logic [DW-1:0] ID_VALUE = 32'h000018FF,
  parameter logic [IRW-1:0] OP_IDCODE = 4'b0001,
  parameter logic [IRW-1:0] OP_WRITE = 4'b0100,
  parameter logic [IRW-1:0] OP_ADDR = 4'b0101,
  parameter logic [IRW-1:0] OP_READ = 4'b0110,
  parameter logic [IRW-1:0] OP_RW = 4'b0111
) (
  input  logic          trst_n,
  input  logic          tck,
  input  logic          tms,
  input  logic          tdi,
  output logic          tdo,
  input  logic          clk,
  input  logic          rst,
  output logic          wb_cyc,
  output logic          wb_stb,
  output logic          wb_we,
  output logic [AW-1:0] wb_adr,
  output logic [DW-1:0] wb_dat_o,
  input  logic [DW-1:0] wb_dat_i,
  input  logic          wb_ack
);
  localparam int SW = (AW > DW) ? AW : DW;
  localparam logic [IRW-1:0] IR_CAP = IRW'(1);

  typedef enum logic [3:0] {
    S_TLR, S_RTI, S_SDR, S_CDR, S_SHDR, S_E1DR, S_PDR, S_E2DR,
    S_UDR, S_SIR, S_CIR, S_SHIR, S_E1IR, S_PIR, S_E2IR, S_UIR
  } tap_e;

  tap_e st, nxt;
  logic [IRW-1:0] ir, ir_sh;
  logic [SW-1:0]  dr_sh;
  logic           byp;
  logic [AW-1:0]  addr, wadr, req_adr;
  logic [DW-1:0]  rd_buf, wbuf, req_dat, rdat_x;
  logic           wr_due, rd_due, req_tgl, req_we;
  logic           ack_s1, ack_s2, ack_s3, ack_tgl;
  logic           rq_s1, rq_s2, rq_s3;
  logic           busy, sel_id, sel_adr, sel_rd, sel_wr, sel_rw, sel_mem, sel_byp;

  always_comb begin
    case (st)
      S_TLR:  nxt = tms ? S_TLR  : S_RTI;
      S_RTI:  nxt = tms ? S_SDR  : S_RTI;
      S_SDR:  nxt = tms ? S_SIR  : S_CDR;
      S_CDR:  nxt = tms ? S_E1DR : S_SHDR;
      S_SHDR: nxt = tms ? S_E1DR : S_SHDR;
      S_E1DR: nxt = tms ? S_UDR  : S_PDR;
      S_PDR:  nxt = tms ? S_E2DR : S_PDR;
      S_E2DR: nxt = tms ? S_UDR  : S_SHDR;
      S_UDR:  nxt = tms ? S_SDR  : S_RTI;
      S_SIR:  nxt = tms ? S_TLR  : S_CIR;
      S_CIR:  nxt = tms ? S_E1IR : S_SHIR;
      S_SHIR: nxt = tms ? S_E1IR : S_SHIR;
      S_E1IR: nxt = tms ? S_UIR  : S_PIR;
      S_PIR:  nxt = tms ? S_E2IR : S_PIR;
      S_E2IR: nxt = tms ? S_UIR  : S_SHIR;
      S_UIR:  nxt = tms ? S_SDR  : S_RTI;
      default: nxt = S_TLR;
    endcase
  end

  assign sel_id  = (ir == OP_IDCODE);
  assign sel_adr = (ir == OP_ADDR);
  assign sel_rd  = (ir == OP_READ);
  assign sel_wr  = (ir == OP_WRITE);
  assign sel_rw  = (ir == OP_RW);
  assign sel_mem = sel_rd | sel_wr | sel_rw;
  assign sel_byp = ~(sel_id | sel_adr | sel_mem);
  assign busy    = req_tgl ^ ack_s3;

  assign tdo = (st == S_SHIR) ? ir_sh[0] :
               (st == S_SHDR) ? (sel_byp ? byp : dr_sh[0]) : 1'b0;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      st <= S_TLR;
      ir <= OP_IDCODE;
      ir_sh <= '0;
      dr_sh <= '0;
      byp <= 1'b0;
      addr <= '0;
      wadr <= '0;
      wbuf <= '0;
      rd_buf <= '0;
      wr_due <= 1'b0;
      rd_due <= 1'b1;
      req_tgl <= 1'b0;
      req_we <= 1'b0;
      req_adr <= '0;
      req_dat <= '0;
      ack_s1 <= 1'b0;
      ack_s2 <= 1'b0;
      ack_s3 <= 1'b0;
    end else begin
      st <= nxt;
      ack_s1 <= ack_tgl;
      ack_s2 <= ack_s1;
      ack_s3 <= ack_s2;
      if ((ack_s2 != ack_s3) && !req_we) rd_buf <= rdat_x;

      if (st != S_TLR && !busy && (wr_due || rd_due)) begin
        req_tgl <= ~req_tgl;
        if (wr_due) begin
          req_we <= 1'b1;
          req_adr <= wadr;
          req_dat <= wbuf;
          wr_due <= 1'b0;
        end else begin
          req_we <= 1'b0;
          req_adr <= addr;
          rd_due <= 1'b0;
        end
      end

      case (st)
        S_TLR: begin
          ir <= OP_IDCODE;
          addr <= '0;
          wr_due <= 1'b0;
          rd_due <= 1'b1;
        end
        S_CIR:  ir_sh <= IR_CAP;
        S_SHIR: ir_sh <= {tdi, ir_sh[IRW-1:1]};
        S_UIR:  ir <= ir_sh;
        S_CDR: begin
          if (sel_byp)      byp <= 1'b0;
          else if (sel_id)  dr_sh <= SW'(ID_VALUE);
          else if (sel_adr) dr_sh <= SW'(addr);
          else if (sel_wr)  dr_sh <= '0;
          else              dr_sh <= SW'(rd_buf);
        end
        S_SHDR: begin
          if (sel_byp)      byp <= tdi;
          else if (sel_adr) dr_sh[AW-1:0] <= {tdi, dr_sh[AW-1:1]};
          else              dr_sh[DW-1:0] <= {tdi, dr_sh[DW-1:1]};
        end
        S_UDR: begin
          if (sel_adr) begin
            addr <= dr_sh[AW-1:0];
            rd_due <= 1'b1;
          end else if (sel_mem) begin
            addr <= addr + AW'(1);
            rd_due <= 1'b1;
            if (!sel_rd) begin
              wr_due <= 1'b1;
              wbuf <= dr_sh[DW-1:0];
              wadr <= addr;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign wb_stb = wb_cyc;

  always_ff @(posedge clk) begin
    if (rst) begin
      rq_s1 <= 1'b0;
      rq_s2 <= 1'b0;
      rq_s3 <= 1'b0;
      wb_cyc <= 1'b0;
      wb_we <= 1'b0;
      wb_adr <= '0;
      wb_dat_o <= '0;
      rdat_x <= '0;
      ack_tgl <= 1'b0;
    end else begin
      rq_s1 <= req_tgl;
      rq_s2 <= rq_s1;
      rq_s3 <= rq_s2;
      if (rq_s2 != rq_s3) begin
        wb_cyc <= 1'b1;
        wb_we <= req_we;
        wb_adr <= req_adr;
        wb_dat_o <= req_dat;
      end else if (wb_cyc && wb_ack) begin
        wb_cyc <= 1'b0;
        if (!wb_we) rdat_x <= wb_dat_i;
        ack_tgl <= ~ack_tgl;
      end
    end
  end
endmodule

module jtag_mem_bridge_chk #(
  parameter int AW = 30,
  parameter int DW = 32,
  parameter int IRW = 4,
  parameter logic [IRW-1:0] OP_IDCODE = 4'b0001
) (
  input logic          trst_n,
  input logic          tck,
  input logic          tms,
  input logic          tdi,
  input logic          tdo,
  input logic          clk,
  input logic          rst,
  input logic          wb_cyc,
  input logic          wb_we,
  input logic          wb_ack,
  input logic [AW-1:0] wb_adr,
  input logic [DW-1:0] wb_dat_o,
  input logic [3:0]    st,
  input logic [IRW-1:0] ir,
  input logic [AW-1:0] addr,
  input logic          sel_byp,
  input logic          sel_mem
);
  localparam logic [3:0] C_TLR = 4'd0, C_SHDR = 4'd4, C_UDR = 4'd8;

  // R10
  bus_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wb_cyc && !wb_ack) |=> (wb_cyc && $stable(wb_adr) && $stable(wb_we) && $stable(wb_dat_o)));
  // R10
  bus_release_chk: assert property (@(posedge clk) disable iff (rst)
    (wb_cyc && wb_ack) |=> !wb_cyc);
  // R1
  tlr_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (st == C_TLR && tms) |=> (st == C_TLR));
  // R1
  tlr_clear_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (st == C_TLR) |=> (ir == OP_IDCODE && addr == '0));
  // R3
  bypass_delay_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (st == C_SHDR && sel_byp) |=> (st != C_SHDR || tdo == $past(tdi)));
  // R9
  addr_step_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (st == C_UDR && sel_mem) |=> (addr == $past(addr) + AW'(1)));
endmodule

bind jtag_mem_bridge jtag_mem_bridge_chk #(.AW(AW), .DW(DW), .IRW(IRW), .OP_IDCODE(OP_IDCODE)) u_chk (
  .trst_n(trst_n), .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo),
  .clk(clk), .rst(rst), .wb_cyc(wb_cyc), .wb_we(wb_we), .wb_ack(wb_ack),
  .wb_adr(wb_adr), .wb_dat_o(wb_dat_o), .st(st), .ir(ir), .addr(addr),
  .sel_byp(sel_byp), .sel_mem(sel_mem)
);

// File: tb/tb_jtag_mem_bridge.sv
`timescale 1ns/1ps
module tb_jtag_mem_bridge;
  localparam int HALF = 30;
  localparam int IDLE = 16;

  logic clk = 1'b0, rst = 1'b1, trst_n = 1'b0;
  logic tck = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic tdo, wb_cyc, wb_stb, wb_we, wb_ack;
  logic [29:0] wb_adr;
  logic [31:0] wb_dat_o, wb_dat_i;
  logic [31:0] mem [16];
  logic [31:0] model [16];
  int n_vec = 0, n_bad = 0, bus_n = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  jtag_mem_bridge dut (
    .trst_n(trst_n), .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo),
    .clk(clk), .rst(rst), .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we),
    .wb_adr(wb_adr), .wb_dat_o(wb_dat_o), .wb_dat_i(wb_dat_i), .wb_ack(wb_ack)
  );

  assign wb_dat_i = mem[wb_adr[3:0]];
  always_ff @(posedge clk) begin
    if (rst) wb_ack <= 1'b0;
    else begin
      wb_ack <= wb_cyc & wb_stb & ~wb_ack;
      if (wb_cyc && wb_stb && wb_we && !wb_ack) mem[wb_adr[3:0]] <= wb_dat_o;
      if (wb_cyc && wb_ack) bus_n <= bus_n + 1;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d, output logic o);
    tms = m;
    tdi = d;
    #HALF;
    o = tdo;
    tck = 1'b1;
    #HALF;
    tck = 1'b0;
  endtask

  task automatic idle(input int n);
    logic o;
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, o);
  endtask

  task automatic shift_ir(input logic [3:0] op, output logic [3:0] cap);
    logic o;
    step(1, 0, o); step(1, 0, o); step(0, 0, o); step(0, 0, o);
    for (int i = 0; i < 4; i++) begin
      step(i == 3, op[i], o);
      cap[i] = o;
    end
    step(1, 0, o); step(0, 0, o);
    idle(2);
  endtask

  task automatic shift_dr(input int n, input logic [31:0] din, output logic [31:0] dout);
    logic o;
    dout = '0;
    step(1, 0, o); step(0, 0, o); step(0, 0, o);
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, din[i], o);
      dout[i] = o;
    end
    step(1, 0, o); step(0, 0, o);
    idle(IDLE);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [3:0] cap;
    logic [31:0] r, w;
    int b0;
    for (int i = 0; i < 16; i++) begin
      mem[i] = 32'h5A00_0000 ^ (32'(i) * 32'h0013_1F07) ^ 32'(i << 28);
      model[i] = mem[i];
    end
    #50;
    rst = 1'b0;
    trst_n = 1'b1;
    #20;
    idle(4);

    shift_dr(32, 32'h0, r);
    check("R1 reset selects id", r, 32'h000018FF);
    shift_ir(4'b0001, cap);
    check("R4 ir capture", {28'h0, cap}, 32'h1);
    shift_dr(32, 32'hFFFF_FFFF, r);
    check("R2 id value", r, 32'h000018FF);

    for (int op = 0; op < 16; op++) begin
      if (!(op == 1 || (op >= 4 && op <= 7))) begin
        logic [7:0] pat;
        pat = 8'hB3 ^ 8'(op * 37);
        shift_ir(4'(op), cap);
        check("R4 ir capture", {28'h0, cap}, 32'h1);
        shift_dr(8, {24'h0, pat}, r);
        check("R3 bypass", r, {24'h0, pat[6:0], 1'b0});
      end
    end

    shift_ir(4'b0101, cap);
    shift_dr(30, 32'd7, r);
    check("R5 address after reset", r, 32'd0);
    shift_dr(30, 32'd0, r);
    check("R5 address shifted out", r, 32'd7);

    shift_ir(4'b0110, cap);
    for (int i = 0; i < 16; i++) begin
      b0 = bus_n;
      shift_dr(32, ~(32'(i) * 32'h0F0F_1234), r);
      check("R7 read word", r, model[i]);
      if (i == 0) check("R10 one cycle per read", 32'(bus_n - b0), 32'd1);
    end
    shift_ir(4'b0101, cap);
    shift_dr(30, 32'd2, r);
    check("R9 address after 16 reads", r, 32'd16);

    shift_ir(4'b0111, cap);
    for (int i = 0; i < 4; i++) begin
      w = 32'hD00D_0000 | 32'(i * 9);
      b0 = bus_n;
      shift_dr(32, w, r);
      check("R6 rw returns old", r, model[2 + i]);
      if (i == 0) check("R10 two cycles per rw", 32'(bus_n - b0), 32'd2);
      model[2 + i] = w;
    end
    shift_ir(4'b0101, cap);
    shift_dr(30, 32'd2, r);
    check("R9 address after rw", r, 32'd6);
    shift_ir(4'b0110, cap);
    for (int i = 0; i < 4; i++) begin
      shift_dr(32, 32'h0, r);
      check("R6 rw stored", r, model[2 + i]);
    end

    shift_ir(4'b0101, cap);
    shift_dr(30, 32'd9, r);
    check("R9 address after reads", r, 32'd6);
    shift_ir(4'b0100, cap);
    for (int i = 0; i < 3; i++) begin
      w = 32'h0BAD_F000 + 32'(i * 3);
      shift_dr(32, w, r);
      check("R8 write captures zero", r, 32'h0);
      model[9 + i] = w;
    end
    shift_ir(4'b0101, cap);
    shift_dr(30, 32'd9, r);
    check("R9 address after writes", r, 32'd12);
    shift_ir(4'b0110, cap);
    for (int i = 0; i < 3; i++) begin
      shift_dr(32, 32'hFFFF_FFFF, r);
      check("R8 write stored", r, model[9 + i]);
    end

    shift_ir(4'b0101, cap);
    shift_dr(30, 32'd0, r);
    shift_ir(4'b0110, cap);
    for (int i = 0; i < 2; i++) begin
      shift_dr(32, 32'h0, r);
      check("R7 read left memory unchanged", r, model[i]);
    end

    shift_ir(4'b0101, cap);
    for (int i = 0; i < 5; i++) step(1, 0, r[0]);
    idle(4);
    shift_dr(32, 32'h0, r);
    check("R1 tms reset selects id", r, 32'h000018FF);
    shift_ir(4'b0101, cap);
    shift_dr(30, 32'd0, r);
    check("R1 tms reset clears address", r, 32'd0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule